// File: doc/BRIEF.md
# Pixel Region Hit Buffer

This block is the digital logic shared by a 2x2 group of pixels in a pixel readout chip. It samples four discriminator outputs on the bunch-crossing clock. It measures how long each pixel stays above threshold and sorts each hit as small or big. Each group of hits is held locally as one event in a small slot buffer, with an age counter that starts at the event's first crossing.

A trigger arrives a programmable latency after the hits. The trigger may cover a run of consecutive crossings. When it matches a buffered event, that event is marked for readout and tagged with the position of its crossing in the trigger run. Events that are never matched are freed when their latency runs out.

Marked events leave through a token chain. A region that holds marked data keeps the token and presents one event per read strobe. A region with nothing to send passes the token on. Small hits that start up to two crossings after the event's first crossing are attached to that event, which removes time walk. An event made only of small hits is dropped.

Top module: `pixreg_hitbuf`

## Requirements
- R1: A pixel hit is counted when its discriminator is sampled high after being sampled low. Its ToT W is the number of consecutive clock edges at which it is sampled high. A big hit with W from 1 to 13 is reported as code W-1, and a hit with W of 14 or more is reported as code 13 (long hit).
- R2: `disc_mode` sets the small-hit limit: 0 means no hit is small, 1 means W<=1 is small, and 2 or 3 mean W<=2 is small. A small hit is reported as code 14. A hit longer than the limit is a big hit.
- R3: In `out_tot`, pixel p occupies bits [4p+3:4p]. A pixel that did not join the event reads code 15 (no hit).
- R4: The edge at which a rising discriminator opens an event is E0. Rising edges sampled at E0, E0+1 and E0+2 join that event. A rise sampled at E0+3 while the event is still open is ignored and does not open a new event.
- R5: An event that holds no big hit is discarded and is never read out, even when a trigger matches it.
- R6: `trig` is sampled at edge E0+k. With latency `lat` (1 to 257) and run length `trig_span`+1 (1 to 16), the trigger matches the event when lat-trig_span <= k <= lat. The event is then read out with `out_idx` = lat-k.
- R7: An event that no trigger matches by age `lat` is freed and never read out.
- R8: The buffer holds five events. A rising discriminator that would open a sixth event while all five slots are in use is dropped and sets `ovf`. `ovf` stays set until reset.
- R9: When `tok_in` is high, one edge later either `out_valid` goes high with the lowest-numbered ready event (and `tok_out` low), or `tok_out` goes high with `out_valid` low when no event is ready. `rd` while `out_valid` is high removes the shown event at that edge.
- R10: `out_nbr` is the OR of `nbr_in` sampled at E0, E0+1 and E0+2.
- R11: After reset, `tok_out`, `out_valid` and `ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| disc | input | 4 | Discriminator outputs, one per pixel |
| nbr_in | input | 1 | Hit seen in the neighbouring region this crossing |
| disc_mode | input | 2 | Small-hit limit select |
| lat | input | 9 | Trigger latency in crossings |
| trig | input | 1 | Trigger strobe |
| trig_span | input | 4 | Consecutive crossings covered by a trigger, minus one |
| tok_in | input | 1 | Read token from the previous region |
| rd | input | 1 | Read strobe; consumes the shown event |
| tok_out | output | 1 | Read token to the next region |
| out_valid | output | 1 | Event data on the outputs is valid |
| out_tot | output | 16 | Four 4-bit ToT codes |
| out_idx | output | 4 | Position of the event in the trigger run |
| out_nbr | output | 1 | Neighbour flag of the event |
| ovf | output | 1 | Sticky buffer overflow flag |

## Verification
A wrong pixel counter or a wrong small-hit limit shows up as a wrong nibble in `out_tot` on the first readout after the trigger. A latency compare that is off by one either drops an event or lets one through at the matching edges k = lat-trig_span and k = lat. Either error is visible as `out_valid` or `tok_out` one edge after `tok_in` rises. Slot bookkeeping errors show up on `ovf` at the sixth event, or later as events that are lost or repeated in the token readout.

// File: rtl/pixreg_pkg.sv
package pixreg_pkg;
  localparam int CODE_W     = 4;
  localparam int CODE_LONG  = 13;
  localparam int CODE_SMALL = 14;
  localparam int CODE_NONE  = 15;
  localparam int TOT_SAT    = 14;

  typedef enum logic [1:0] {PX_IDLE, PX_CNT, PX_DONE} px_st_t;

  // small-hit limit in counts: 0 disables small hits
  function automatic logic [CODE_W-1:0] small_thr(input logic [1:0] mode);
    case (mode)
      2'd0:    small_thr = CODE_W'(0);
      2'd1:    small_thr = CODE_W'(1);
      default: small_thr = CODE_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/pixreg_pixel.sv
module pixreg_pixel
  import pixreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              disc,
  input  logic              join_ok,
  input  logic              clear,
  input  logic [CODE_W-1:0] thr,
  output logic              rise,
  output logic              busy,
  output logic              big,
  output logic [CODE_W-1:0] code
);
  logic              dq;
  px_st_t            st;
  logic [CODE_W-1:0] cnt;

  assign rise = disc & ~dq;
  assign busy = (st == PX_CNT);
  assign big  = (st != PX_IDLE) && (cnt > thr);

  always_comb begin
    if (st == PX_IDLE)                code = CODE_W'(CODE_NONE);
    else if (cnt >= CODE_W'(TOT_SAT)) code = CODE_W'(CODE_LONG);
    else if (cnt <= thr)              code = CODE_W'(CODE_SMALL);
    else                              code = cnt - CODE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq  <= 1'b0;
      st  <= PX_IDLE;
      cnt <= '0;
    end else begin
      dq <= disc;
      if (clear) begin
        st  <= PX_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          PX_IDLE: if (rise && join_ok) begin
            st  <= PX_CNT;
            cnt <= CODE_W'(1);
          end
          PX_CNT: begin
            if (!disc) st <= PX_DONE;
            else if (cnt == CODE_W'(TOT_SAT - 1)) begin
              cnt <= CODE_W'(TOT_SAT);
              st  <= PX_DONE;
            end else cnt <= cnt + CODE_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  // R1: a finished count is frozen until the event closes
  p_done_frozen_r1: assert property (@(posedge clk) disable iff (rst)
    (st == PX_DONE && !clear) |=> $stable(cnt));
endmodule

// File: rtl/pixreg_slots.sv
module pixreg_slots
  import pixreg_pkg::*;
#(
  parameter int NPIX   = 4,
  parameter int NSLOT  = 5,
  parameter int LAT_W  = 9,
  parameter int SPAN_W = 4,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int TOT_W  = CODE_W * NPIX
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic              close_we,
  input  logic [SLOT_W-1:0] close_slot,
  input  logic              close_keep,
  input  logic [TOT_W-1:0]  close_tot,
  input  logic              close_nbr,
  input  logic              trig,
  input  logic [SPAN_W-1:0] span,
  input  logic [LAT_W-1:0]  lat,
  input  logic              tok_in,
  input  logic              rd,
  output logic              any_free,
  output logic [SLOT_W-1:0] free_idx,
  output logic              tok_out,
  output logic              out_valid,
  output logic [TOT_W-1:0]  out_tot,
  output logic [SPAN_W-1:0] out_idx,
  output logic              out_nbr
);
  logic [NSLOT-1:0]  v, cl, mk, match, expire, rdhit, ready;
  logic [LAT_W-1:0]  age  [NSLOT];
  logic [TOT_W-1:0]  tot  [NSLOT];
  logic [SPAN_W-1:0] idx  [NSLOT];
  logic [NSLOT-1:0]  nb;
  logic [SLOT_W-1:0] out_slot, sel;
  logic              any_ready;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    any_ready = 1'b0;
    sel = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (!v[s]) begin
        any_free = 1'b1;
        free_idx = SLOT_W'(s);
      end
      if (ready[s]) begin
        any_ready = 1'b1;
        sel = SLOT_W'(s);
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [LAT_W:0] reach;
    assign reach    = {1'b0, age[s]} + (LAT_W+1)'(span);
    assign match[s] = trig && v[s] && !mk[s] && (age[s] <= lat) && (reach >= {1'b0, lat});
    assign expire[s] = v[s] && cl[s] && !mk[s] && !match[s] && (age[s] >= lat);
    assign rdhit[s] = rd && out_valid && (out_slot == SLOT_W'(s));
    assign ready[s] = v[s] && cl[s] && mk[s] && !rdhit[s];

    always_ff @(posedge clk) begin
      if (rst) begin
        v[s]   <= 1'b0;
        cl[s]  <= 1'b0;
        mk[s]  <= 1'b0;
        age[s] <= '0;
        tot[s] <= '0;
        idx[s] <= '0;
        nb[s]  <= 1'b0;
      end else if (alloc && free_idx == SLOT_W'(s)) begin
        v[s]   <= 1'b1;
        cl[s]  <= 1'b0;
        mk[s]  <= 1'b0;
        age[s] <= LAT_W'(1);
      end else if (v[s]) begin
        if (age[s] != '1) age[s] <= age[s] + LAT_W'(1);
        if (match[s]) begin
          mk[s]  <= 1'b1;
          idx[s] <= SPAN_W'(lat - age[s]);
        end
        if (close_we && close_slot == SLOT_W'(s)) begin
          if (!close_keep) v[s] <= 1'b0;
          cl[s]  <= 1'b1;
          tot[s] <= close_tot;
          nb[s]  <= close_nbr;
        end
        if (expire[s] || rdhit[s]) v[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      tok_out   <= 1'b0;
      out_slot  <= '0;
      out_tot   <= '0;
      out_idx   <= '0;
      out_nbr   <= 1'b0;
    end else begin
      out_valid <= tok_in && any_ready;
      tok_out   <= tok_in && !any_ready;
      out_slot  <= sel;
      out_tot   <= tot[sel];
      out_idx   <= idx[sel];
      out_nbr   <= nb[sel];
    end
  end

  // R9: a region never drives data and forwards the token at once
  p_tok_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(tok_out && out_valid));
  // R9: the read event is gone after the read edge
  p_rd_frees_r9: assert property (@(posedge clk) disable iff (rst)
    (rd && out_valid) |=> !v[$past(out_slot)]);
endmodule

// File: rtl/pixreg_hitbuf.sv
module pixreg_hitbuf
  import pixreg_pkg::*;
#(
  parameter int NPIX   = 4,
  parameter int NSLOT  = 5,
  parameter int LAT_W  = 9,
  parameter int SPAN_W = 4,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int TOT_W  = CODE_W * NPIX
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIX-1:0]   disc,
  input  logic              nbr_in,
  input  logic [1:0]        disc_mode,
  input  logic [LAT_W-1:0]  lat,
  input  logic              trig,
  input  logic [SPAN_W-1:0] trig_span,
  input  logic              tok_in,
  input  logic              rd,
  output logic              tok_out,
  output logic              out_valid,
  output logic [TOT_W-1:0]  out_tot,
  output logic [SPAN_W-1:0] out_idx,
  output logic              out_nbr,
  output logic              ovf
);
  logic [NPIX-1:0]   rise, busy, big;
  logic [TOT_W-1:0]  codes;
  logic [CODE_W-1:0] thr;
  logic              ev_open, nbr_acc, any_free, join_ok, alloc, close_ev;
  logic [SLOT_W-1:0] ev_slot, free_idx;
  logic [1:0]        win;

  assign thr      = small_thr(disc_mode);
  assign join_ok  = ev_open ? (win != 2'd3) : any_free;
  assign alloc    = !ev_open && (|rise) && any_free;
  assign close_ev = ev_open && (win == 2'd3) && !(|busy);

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    pixreg_pixel u_pix (
      .clk     (clk),
      .rst     (rst),
      .disc    (disc[p]),
      .join_ok (join_ok),
      .clear   (close_ev),
      .thr     (thr),
      .rise    (rise[p]),
      .busy    (busy[p]),
      .big     (big[p]),
      .code    (codes[p*CODE_W +: CODE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_open <= 1'b0;
      ev_slot <= '0;
      win     <= '0;
      nbr_acc <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (!ev_open && (|rise) && !any_free) ovf <= 1'b1;
      if (alloc) begin
        ev_open <= 1'b1;
        ev_slot <= free_idx;
        win     <= 2'd1;
        nbr_acc <= nbr_in;
      end else if (close_ev) begin
        ev_open <= 1'b0;
      end else if (ev_open) begin
        if (win != 2'd3) begin
          win     <= win + 2'd1;
          nbr_acc <= nbr_acc | nbr_in;
        end
      end
    end
  end

  pixreg_slots #(.NPIX(NPIX), .NSLOT(NSLOT), .LAT_W(LAT_W), .SPAN_W(SPAN_W)) u_slots (
    .clk        (clk),
    .rst        (rst),
    .alloc      (alloc),
    .close_we   (close_ev),
    .close_slot (ev_slot),
    .close_keep (|big),
    .close_tot  (codes),
    .close_nbr  (nbr_acc),
    .trig       (trig),
    .span       (trig_span),
    .lat        (lat),
    .tok_in     (tok_in),
    .rd         (rd),
    .any_free   (any_free),
    .free_idx   (free_idx),
    .tok_out    (tok_out),
    .out_valid  (out_valid),
    .out_tot    (out_tot),
    .out_idx    (out_idx),
    .out_nbr    (out_nbr)
  );

  // R8: overflow flag is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

// File: tb/tb_pixreg_hitbuf.sv
module tb_pixreg_hitbuf;
  logic clk = 1'b0;
  logic rst, nbr_in, trig, tok_in, rd;
  logic [3:0] disc, trig_span;
  logic [1:0] disc_mode;
  logic [8:0] lat;
  logic tok_out, out_valid, out_nbr, ovf;
  logic [15:0] out_tot;
  logic [3:0] out_idx;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int w[4], off[4];
  int nbr_at, trig_at, span_v, n_edges;

  always #4 clk = ~clk;

  pixreg_hitbuf dut (
    .clk(clk), .rst(rst), .disc(disc), .nbr_in(nbr_in), .disc_mode(disc_mode),
    .lat(lat), .trig(trig), .trig_span(trig_span), .tok_in(tok_in), .rd(rd),
    .tok_out(tok_out), .out_valid(out_valid), .out_tot(out_tot),
    .out_idx(out_idx), .out_nbr(out_nbr), .ovf(ovf)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1; disc = '0; nbr_in = 1'b0; trig = 1'b0; tok_in = 1'b0; rd = 1'b0;
    trig_span = '0;
    tick; tick;
    rst = 1'b0;
  endtask

  function automatic int thr_of(input int mode);
    return (mode == 0) ? 0 : ((mode == 1) ? 1 : 2);
  endfunction

  function automatic int code_of(input int wd, input int mode);
    if (wd == 0) return 15;
    if (wd >= 14) return 13;
    if (wd <= thr_of(mode)) return 14;
    return wd - 1;
  endfunction

  task automatic play;
    for (int j = 0; j < n_edges; j++) begin
      for (int p = 0; p < 4; p++)
        disc[p] = (w[p] > 0) && (j >= off[p]) && (j < off[p] + w[p]);
      trig      = (j == trig_at);
      trig_span = 4'(span_v);
      nbr_in    = (j == nbr_at);
      tick;
    end
    disc = '0; trig = 1'b0; nbr_in = 1'b0;
  endtask

  task automatic readout(input string tag, input bit exp_v, input int exp_tot,
                         input int exp_idx, input int exp_nbr, input bit last);
    tok_in = 1'b1;
    tick;
    chk({tag, " valid"}, int'(out_valid), int'(exp_v));
    chk({tag, " token"}, int'(tok_out), int'(!exp_v));
    if (exp_v) begin
      chk({tag, " tot"}, int'(out_tot), exp_tot);
      chk({tag, " idx"}, int'(out_idx), exp_idx);
      chk({tag, " nbr"}, int'(out_nbr), exp_nbr);
      rd = 1'b1;
      tick;
      rd = 1'b0;
      if (last) begin
        chk({tag, " R9 empty after read"}, int'(out_valid), 0);
        chk({tag, " R9 token after read"}, int'(tok_out), 1);
      end
    end
    if (last) tok_in = 1'b0;
  endtask

  // expected result of the play() set-up with E0 at j=0
  task automatic run_expect(input string tag, input int mode);
    int tot_e, keep, k, m;
    tot_e = 0; keep = 0;
    for (int p = 0; p < 4; p++) begin
      int c;
      c = (w[p] > 0 && off[p] <= 2) ? code_of(w[p], mode) : 15;
      if (w[p] > 0 && off[p] <= 2 && w[p] > thr_of(mode)) keep = 1;
      tot_e |= c << (4 * p);
    end
    k = trig_at;
    m = keep && (k >= 0) && (k <= int'(lat)) && (k >= int'(lat) - span_v);
    disc_mode = 2'(mode);
    play;
    readout(tag, m[0], tot_e, int'(lat) - k, (nbr_at >= 0 && nbr_at <= 2) ? 1 : 0, 1'b1);
  endtask

  task automatic setup(input int w0, input int w1, input int w2, input int w3,
                       input int o0, input int o1, input int o2, input int o3);
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    off[0] = o0; off[1] = o1; off[2] = o2; off[3] = o3;
    nbr_at = -1; span_v = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    disc_mode = 2'd0; lat = 9'd20;
    do_reset;
    chk("R11 tok_out", int'(tok_out), 0);
    chk("R11 out_valid", int'(out_valid), 0);
    chk("R11 ovf", int'(ovf), 0);
    // R9 pass-through with an empty region
    tok_in = 1'b1; tick;
    chk("R9 pass tok_out", int'(tok_out), 1);
    chk("R9 pass out_valid", int'(out_valid), 0);
    tok_in = 1'b0; tick;

    // R1 R2 R3: width sweep on pixel 0 in every mode
    for (int mode = 0; mode < 3; mode++)
      for (int wd = 1; wd <= 15; wd++) begin
        do_reset;
        setup(wd, 5, 0, 0, 0, 1, 0, 0);
        lat = 9'd20; trig_at = 20; n_edges = 26;
        run_expect($sformatf("R1 R2 R3 mode%0d w%0d", mode, wd), mode);
      end
    // mode 3 behaves as mode 2
    do_reset; setup(2, 3, 0, 0, 0, 0, 0, 0); lat = 9'd20; trig_at = 20; n_edges = 26;
    run_expect("R2 mode3", 3);

    // R4 association window
    do_reset; setup(4, 3, 2, 5, 0, 1, 2, 3); lat = 9'd20; trig_at = 20; n_edges = 26;
    run_expect("R4 window", 0);
    do_reset; setup(1, 1, 1, 9, 0, 1, 2, 3); lat = 9'd20; trig_at = 20; n_edges = 26;
    run_expect("R4 R5 late big ignored", 1);

    // R5 small-only events
    do_reset; setup(1, 0, 0, 0, 0, 0, 0, 0); lat = 9'd20; trig_at = 20; n_edges = 26;
    run_expect("R5 single small", 1);
    do_reset; setup(2, 1, 2, 0, 0, 1, 2, 0); lat = 9'd20; trig_at = 20; n_edges = 26;
    run_expect("R5 all small", 2);

    // R6 R7 latency window sweep
    for (int k = 6; k <= 13; k++) begin
      do_reset; setup(3, 0, 0, 0, 0, 0, 0, 0); span_v = 2;
      lat = 9'd10; trig_at = k; n_edges = 16;
      run_expect($sformatf("R6 R7 lat10 k%0d", k), 0);
    end
    for (int k = 256; k <= 258; k++) begin
      do_reset; setup(6, 0, 0, 0, 0, 0, 0, 0);
      lat = 9'd257; trig_at = k; n_edges = 262;
      run_expect($sformatf("R6 R7 lat257 k%0d", k), 0);
    end
    for (int k = 241; k <= 242; k++) begin
      do_reset; setup(6, 0, 0, 0, 0, 0, 0, 0); span_v = 15;
      lat = 9'd257; trig_at = k; n_edges = 262;
      run_expect($sformatf("R6 lat257 span16 k%0d", k), 0);
    end
    do_reset; setup(6, 0, 0, 0, 0, 0, 0, 0);
    lat = 9'd257; trig_at = -1; n_edges = 262;
    run_expect("R7 no trigger", 0);

    // R10 neighbour flag
    do_reset; setup(4, 0, 0, 0, 0, 0, 0, 0); nbr_at = 2;
    lat = 9'd20; trig_at = 20; n_edges = 26;
    run_expect("R10 nbr in window", 0);
    do_reset; setup(4, 0, 0, 0, 0, 0, 0, 0); nbr_at = 3;
    lat = 9'd20; trig_at = 20; n_edges = 26;
    run_expect("R10 nbr late", 0);

    // R6 R9 two events in one trigger run, read in slot order
    do_reset; lat = 9'd20; disc_mode = 2'd0;
    for (int j = 0; j < 26; j++) begin
      disc[0] = (j < 3);
      disc[1] = (j >= 10 && j < 14);
      trig = (j == 20); trig_span = 4'd15;
      tick;
    end
    disc = '0; trig = 1'b0;
    readout("R6 R9 first", 1'b1, 16'hFFF2, 0, 0, 1'b0);
    readout("R6 R9 second", 1'b1, 16'hFF3F, 10, 0, 1'b1);

    // R8 overflow on the sixth pending event
    do_reset; lat = 9'd200; disc_mode = 2'd0;
    for (int j = 0; j < 36; j++) begin
      if (j == 30) chk("R8 five held", int'(ovf), 0);
      disc[0] = ((j % 6) < 2);
      tick;
      if (j == 30) chk("R8 sixth dropped", int'(ovf), 1);
    end
    disc = '0;
    repeat (10) tick;
    chk("R8 sticky", int'(ovf), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule